// File: doc/BRIEF.md
# Rotating Wear-Spread Nonvolatile Counter

This block keeps a 32-bit event count in a small byte-wide nonvolatile store. The count is not stored at one fixed location. Each increment writes the new value into the next of N slots, one after another, and wraps back to the first slot after the last. Each location therefore receives only one write in every N, and its program/erase endurance goes N times further. The slots are placed a configurable stride apart, so each one can sit in its own erase group.

The storage side is a plain synchronous byte port. The block raises a request together with an address, a write flag and a data byte. A transfer takes place on a clock edge where both request and ready are high, and read data is taken in that same cycle. After a reset the block reads every slot, takes the largest value as the current count, and resumes writing in the slot after the one that held it. While that scan runs, or while a slot is being written, busy is high and increment requests are dropped.

Top module: `wear_spread_counter`

## Requirements
- R1: Each accepted increment writes the new count into the current slot and then moves to the next slot index, which returns to 0 after index N-1. Starting from an empty store, count k therefore goes to slot (k-1) mod N.
- R2: An increment changes only the four bytes of its target slot. Every other byte of the store keeps its value.
- R3: Slot i occupies addresses BASE+i*STRIDE to BASE+i*STRIDE+3. Byte j of the slot holds count bits 8j+7 down to 8j (least significant byte at the lowest address). No access falls outside the slot area.
- R4: A byte transfer completes only on an edge where mem_req and mem_ready are both high. While ready is low, the address, write flag and write data stay stable.
- R5: The count output changes to the new value only after the last byte of the slot has been written, and each increment raises it by exactly 1.
- R6: After reset, busy is high while all N slots are read. When the scan ends, the count equals the largest value found in any slot.
- R7: A slot that reads as all ones (0xFFFFFFFF) counts as 0. If every slot is empty, the count is 0 and the first increment goes to slot 0.
- R8: After recovery, the next increment is written to slot (m+1) mod N, where m is the slot that held the largest value.
- R9: An inc_req seen while busy is high is ignored. It does not change the count or the store.
- R10: The block issues no write while the power-up scan runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the recovery scan |
| inc_req | input | 1 | Increment request, taken only while busy is low |
| busy | output | 1 | High during the recovery scan and during a slot write |
| count | output | CW | Current counter value |
| mem_req | output | 1 | Store access request |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data byte, taken on the completing edge |
| mem_ready | input | 1 | Store accepts or returns the byte on this edge |

## Verification
The hardest case to reach from the ports is recovery when the largest value sits in an arbitrary slot, with empty slots mixed in and values that use all four bytes. The bench loads the storage model directly with such patterns, placing the maximum in every slot position in turn, and then applies reset. It checks the recovered count and where the next increment lands. A pseudo-random ready pattern stalls transfers throughout the run. Increment pulses are also driven during the scan and in the middle of slot writes, so dropped requests are seen at the count and in a byte-by-byte comparison of the whole store.

// File: rtl/wsc_pkg.sv
// Package: shared state type for the rotating wear-spread counter.
// Assumes: used only by the modules of this block.
package wsc_pkg;
    typedef enum logic [1:0] {
        ST_SCAN   = 2'd0,   // reading slots after reset
        ST_SETTLE = 2'd1,   // load recovered count
        ST_IDLE   = 2'd2,   // waiting for an increment
        ST_WRITE  = 2'd3    // writing the new count bytes
    } wsc_state_t;
endpackage

// File: rtl/wsc_slot_addr.sv
// wsc_slot_addr: maps a slot index and a byte index to a store address.
// Assumes: STRIDE >= bytes per slot, and the slot area fits in AW bits.
module wsc_slot_addr #(
    parameter int AW     = 8,
    parameter int BASE   = 0,
    parameter int STRIDE = 8,
    parameter int IW     = 3,
    parameter int BW     = 2
) (
    input  logic [IW-1:0] slot_idx,
    input  logic [BW-1:0] byte_idx,
    output logic [AW-1:0] addr
);
    // Address = base + slot * stride + byte offset
    always_comb begin
        addr = AW'(BASE + int'(slot_idx) * STRIDE + int'(byte_idx));
    end
endmodule

// File: rtl/wsc_max_track.sv
// wsc_max_track: keeps the largest slot value seen during the scan and
// the slot that held it. An all-ones word counts as an empty slot (0).
// Assumes: sample values are distinct or ties may keep the earlier slot.
module wsc_max_track #(
    parameter int CW = 32,
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [CW-1:0] smp_word,
    input  logic [IW-1:0] smp_idx,
    output logic [CW-1:0] best_val,
    output logic [IW-1:0] best_idx
);
    logic [CW-1:0] smp_val;

    // Erased slot reads as all ones and stands for zero
    always_comb begin
        smp_val = (smp_word == {CW{1'b1}}) ? '0 : smp_word;
    end

    // Record a strictly larger sample and its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_val <= '0;
            best_idx <= IW'(N - 1);
        end else if (smp_valid && (smp_val > best_val)) begin
            best_val <= smp_val;
            best_idx <= smp_idx;
        end
    end

    assert_max_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        best_val >= $past(best_val));
endmodule

// File: rtl/wear_spread_counter.sv
// wear_spread_counter: counter held in N nonvolatile slots written in
// rotation. After reset the slots are scanned and the largest value is
// taken as the count; each increment writes count+1 into the next slot,
// one byte per transfer, least significant byte first.
// Assumes: a byte store with req/ready handshake and read data valid on
// the completing edge; erased bytes read 0xFF.
module wear_spread_counter #(
    parameter int N      = 5,
    parameter int STRIDE = 8,
    parameter int BASE   = 0,
    parameter int AW     = 8,
    parameter int CW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_req,
    output logic          busy,
    output logic [CW-1:0] count,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_ready
);
    import wsc_pkg::*;

    localparam int BPS = CW / 8;
    localparam int IW  = (N > 1) ? $clog2(N) : 1;
    localparam int BW  = (BPS > 1) ? $clog2(BPS) : 1;
    localparam int LAST_ADDR = BASE + (N - 1) * STRIDE + BPS - 1;

    wsc_state_t    state_q;
    logic [IW-1:0] slot_q;
    logic [BW-1:0] byte_q;
    logic [IW-1:0] next_slot_q;
    logic [CW-1:0] asm_q;
    logic [CW-1:0] wval_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] full_word;
    logic [CW-1:0] best_val;
    logic [IW-1:0] best_idx;
    logic [IW-1:0] slot_sel;
    logic          beat;
    logic          last_byte;
    logic          scan_phase;
    logic          write_phase;

    // Wrap a slot index back to zero after the last slot
    function automatic logic [IW-1:0] wrap_next(input logic [IW-1:0] idx);
        return (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
    endfunction

    // Decode phase flags and handshake completion
    always_comb begin
        scan_phase  = (state_q == ST_SCAN);
        write_phase = (state_q == ST_WRITE);
        beat        = (scan_phase || write_phase) && mem_ready;
        last_byte   = (byte_q == BW'(BPS - 1));
        slot_sel    = write_phase ? next_slot_q : slot_q;
    end

    // Complete slot word: assembled low bytes plus the byte on the port now
    always_comb begin
        full_word = asm_q;
        full_word[CW-1 -: 8] = mem_rdata;
    end

    wsc_slot_addr #(
        .AW(AW), .BASE(BASE), .STRIDE(STRIDE), .IW(IW), .BW(BW)
    ) u_addr (
        .slot_idx (slot_sel),
        .byte_idx (byte_q),
        .addr     (mem_addr)
    );

    wsc_max_track #(
        .CW(CW), .N(N), .IW(IW)
    ) u_max (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (scan_phase && beat && last_byte),
        .smp_word  (full_word),
        .smp_idx   (slot_q),
        .best_val  (best_val),
        .best_idx  (best_idx)
    );

    // Drive the store port from the current phase
    always_comb begin
        mem_req   = scan_phase || write_phase;
        mem_we    = write_phase;
        mem_wdata = wval_q[8*byte_q +: 8];
    end

    // Main sequencer: scan, settle, idle, write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_SCAN;
            slot_q      <= '0;
            byte_q      <= '0;
            next_slot_q <= '0;
            asm_q       <= '0;
            wval_q      <= '0;
            count_q     <= '0;
        end else begin
            case (state_q)
                ST_SCAN: if (beat) begin
                    asm_q[8*byte_q +: 8] <= mem_rdata;
                    if (last_byte) begin
                        byte_q <= '0;
                        if (slot_q == IW'(N - 1)) state_q <= ST_SETTLE;
                        else                      slot_q  <= slot_q + 1'b1;
                    end else begin
                        byte_q <= byte_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    count_q     <= best_val;
                    next_slot_q <= wrap_next(best_idx);
                    state_q     <= ST_IDLE;
                end
                ST_IDLE: if (inc_req) begin
                    wval_q  <= count_q + 1'b1;
                    byte_q  <= '0;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: if (beat) begin
                    if (last_byte) begin
                        byte_q      <= '0;
                        count_q     <= wval_q;
                        next_slot_q <= wrap_next(next_slot_q);
                        state_q     <= ST_IDLE;
                    end else begin
                        byte_q <= byte_q + 1'b1;
                    end
                end
                default: state_q <= ST_SCAN;
            endcase
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign count = count_q;

    // R6: the cycle after a reset cycle the block is busy scanning
    assert_busy_after_reset_R6: assert property (@(posedge clk)
        !rst_n |=> busy);

    // R10: no write is issued during the recovery scan
    assert_scan_read_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        scan_phase |-> !mem_we);

    // R4: a stalled request holds its address, direction and data
    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R3: every access stays inside the slot area
    assert_addr_in_area_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (int'(mem_addr) >= BASE && int'(mem_addr) <= LAST_ADDR));

    // R5: a count change coming out of a write is a step of exactly one
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(count_q) && $past(write_phase)) |-> (count_q == $past(count_q) + 1'b1));

    // R9: a request while busy never starts a second write on its own
    assert_write_only_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> busy);
endmodule

// File: tb/sim_wear_spread_counter.sv
// Bench: byte store model with random ready stalls, shadow copy of the
// expected store contents, increments from empty, dropped requests, and
// recovery sweeps with the maximum placed in every slot.
module sim_wear_spread_counter;
    localparam int N = 5, STRIDE = 8, BASE = 4, AW = 8, CW = 32;
    localparam int MEMSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inc_req = 1'b0;
    logic          busy;
    logic [CW-1:0] count;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic [7:0]    mem [MEMSZ];
    logic [7:0]    shd [MEMSZ];
    logic [7:0]    lfsr = 8'hA5;
    int            checks = 0, errs = 0, cycles = 0;
    bit            timed_out = 0;

    always #2.5 clk = ~clk;

    wear_spread_counter #(.N(N), .STRIDE(STRIDE), .BASE(BASE), .AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .inc_req(inc_req), .busy(busy), .count(count),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // Store model: combinational read, write on a completing edge
    assign mem_rdata = mem[mem_addr];
    assign mem_ready = lfsr[0] | lfsr[1];
    always @(posedge clk) if (mem_req && mem_we && mem_ready) mem[mem_addr] <= mem_wdata;
    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !timed_out) begin
            timed_out = 1;
            errs++; checks++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [CW-1:0] act,
                         input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_base(input int i);
        return BASE + i * STRIDE;
    endfunction

    function automatic logic [CW-1:0] mem_slot(input int i);
        logic [CW-1:0] v;
        for (int j = 0; j < 4; j++) v[8*j +: 8] = mem[slot_base(i) + j];
        return v;
    endfunction

    // Load a slot in both the model and the shadow
    task automatic put_both(input int i, input logic [CW-1:0] v);
        for (int j = 0; j < 4; j++) begin
            mem[slot_base(i) + j] = v[8*j +: 8];
            shd[slot_base(i) + j] = v[8*j +: 8];
        end
    endtask

    task automatic put_shd(input int i, input logic [CW-1:0] v);
        for (int j = 0; j < 4; j++) shd[slot_base(i) + j] = v[8*j +: 8];
    endtask

    function automatic int diff_bytes();
        int d = 0;
        for (int a = 0; a < MEMSZ; a++) if (mem[a] !== shd[a]) d++;
        return d;
    endfunction

    task automatic wait_idle();
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (!busy) return;
        end
    endtask

    task automatic erase_all();
        for (int a = 0; a < MEMSZ; a++) begin
            mem[a] = 8'hFF;
            shd[a] = 8'hFF;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b1, "R6 busy during scan", {31'b0, busy}, 1);
    endtask

    task automatic do_inc();
        @(negedge clk); inc_req = 1'b1;
        @(negedge clk); inc_req = 1'b0;
        wait_idle();
    endtask

    initial begin
        logic [CW-1:0] exp_cnt;
        logic [CW-1:0] big;
        int            sidx;
        erase_all();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);

        // Empty store: scan, with a request dropped during the scan
        do_reset();
        inc_req = 1'b1; @(negedge clk); inc_req = 1'b0;
        wait_idle();
        check(count === 0, "R7 empty store gives 0", count, 0);
        check(diff_bytes() == 0, "R10/R9 scan left store untouched", diff_bytes(), 0);

        // Increments from empty: slot (k-1) mod N gets k
        exp_cnt = 0;
        for (int k = 1; k <= 12; k++) begin
            do_inc();
            exp_cnt = k;
            put_shd((k - 1) % N, exp_cnt);
            check(count === exp_cnt, "R5 count after increment", count, exp_cnt);
            check(mem_slot((k - 1) % N) === exp_cnt, "R1 slot holds new count",
                  mem_slot((k - 1) % N), exp_cnt);
            check(diff_bytes() == 0, "R2/R3/R4 only target slot bytes changed", diff_bytes(), 0);
        end

        // Requests during a write are dropped
        @(negedge clk); inc_req = 1'b1;
        @(negedge clk); inc_req = 1'b0;
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            if (busy) begin
                inc_req = 1'b1;
                @(negedge clk); inc_req = 1'b0;
            end
        end
        wait_idle();
        repeat (4) @(negedge clk);
        exp_cnt = 13; put_shd(12 % N, exp_cnt);
        check(count === exp_cnt, "R9 one step despite busy requests", count, exp_cnt);
        check(diff_bytes() == 0, "R9 store has one slot write", diff_bytes(), 0);

        // Recovery with the store kept
        do_reset(); wait_idle();
        check(count === 13, "R6 recovered count", count, 13);
        do_inc();
        put_shd(13 % N, 14);
        check(mem_slot(13 % N) === 14, "R8 next slot after recovery", mem_slot(13 % N), 14);
        check(diff_bytes() == 0, "R2 recovery increment only one slot", diff_bytes(), 0);

        // Maximum placed in every slot, one empty slot right after it
        for (int p = 0; p < N; p++) begin
            erase_all();
            big = 32'h0102_0300 + 32'(7 * p);
            put_both(p, big);
            for (int i = 2; i < N; i++) put_both((p + i) % N, big - 32'(i));
            do_reset(); wait_idle();
            check(count === big, "R6/R7 recovered maximum", count, big);
            do_inc();
            sidx = (p + 1) % N;
            put_shd(sidx, big + 1);
            check(count === big + 1, "R5 step after recovery", count, big + 1);
            check(mem_slot(sidx) === big + 1, "R8 write lands after maximum",
                  mem_slot(sidx), big + 1);
            check(diff_bytes() == 0, "R3 byte order and placement", diff_bytes(), 0);
        end

        // All empty again: first write goes to slot 0
        erase_all();
        do_reset(); wait_idle();
        do_inc();
        put_shd(0, 1);
        check(mem_slot(0) === 1, "R7 first write in slot 0", mem_slot(0), 1);
        check(diff_bytes() == 0, "R7 store after first write", diff_bytes(), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule